// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Underrun Recovery

This block is the transmit half of a synchronous serial port. A host writes a word into a holding register. At the start of the next transmit slot the held word moves into a shift register, and it is then clocked out most significant bit first, one bit per pulse of a bit-clock enable. The bit clock and the frame sync come from outside the block.

There are two slot disciplines, selected by `net_mode`. In normal mode, every frame sync opens a transmit slot. In network mode, a frame sync opens a transmit slot only when `slot_en` is high. A slot whose enable is low drives a quiet line, and it changes no flag.

When a transmit slot opens with no fresh word, the block sends the previous word again and raises an underrun flag. A host can avoid this by writing the slot register, which accepts the repeat without raising an error. The underrun flag has no interrupt of its own. Instead it selects which of two vectors goes with the transmit interrupt request. To clear the flag, the host must first read the status while the flag is set, and then write either the data register or the slot register.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` and `tx_irq` are 0 and `tx_vec` equals `VEC_OK`. A status read returns 2'b01, where bit 0 is transmit-empty and bit 1 is underrun.
- R2: A data write clears transmit-empty. It also overwrites any word that is still held, so the last word written before a slot is the one that slot sends.
- R3: At a transmit slot start, the new word's MSB appears on `txd` after that same bit enable. Each later bit enable presents the next bit. After all `WORD_W` bits have gone out, `txd` is 0.
- R4: In normal mode every frame sync opens a transmit slot, and `slot_en` has no effect.
- R5: In network mode a frame sync with `slot_en` low opens no transmit slot. For that slot `txd` stays 0, the held word is kept, and neither flag changes.
- R6: A transmit slot that opens with no new word and no slot-register write sets the underrun flag, and the previous word is sent again. This holds in both modes.
- R7: A slot-register write clears transmit-empty. The next transmit slot then sends the previous word again without setting the underrun flag.
- R8: `tx_irq` is a register of (transmit-empty AND `tx_ie`). `tx_vec` is a register of `VEC_EXC` when the underrun flag is set and `VEC_OK` otherwise. Both lag the flags by one cycle.
- R9: The underrun flag clears on a data write or a slot-register write, but only if an earlier status read saw the flag set. A write that has no such read before it leaves the flag set.
- R10: On `host_rd_stat`, `stat_rdata` captures {underrun, empty} on the next edge and holds that value until the next read.
- R11: Transmit-empty is set at every transmit slot start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | One-cycle bit-clock enable |
| fsync | input | 1 | Frame sync, sampled with `bclk_en` |
| net_mode | input | 1 | 1 selects network mode, 0 selects normal mode |
| slot_en | input | 1 | Current slot is active (used in network mode only) |
| host_wr_data | input | 1 | Write strobe for the transmit data register |
| host_wdata | input | WORD_W | Write data |
| host_wr_slot | input | 1 | Write strobe for the slot register (no data) |
| host_rd_stat | input | 1 | Status read strobe |
| tx_ie | input | 1 | Transmit interrupt enable |
| stat_rdata | output | 2 | Captured status: bit 1 underrun, bit 0 empty |
| txd | output | 1 | Serial data out |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_vec | output | VEC_W | Interrupt vector (`VEC_OK` or `VEC_EXC`) |

## Verification
Each output is due a fixed number of cycles after the event that changes it:
- `txd` changes one edge after each bit enable.
- `stat_rdata` is valid one edge after the read strobe.
- `tx_irq` and `tx_vec` follow a flag change one edge later, which is two edges after the write or slot start that caused it.

The bench drives every strobe for exactly one cycle between falling edges and samples at the following falling edge, after all of these delays have elapsed. A scoreboard queue holds the expected bit for each bit enable, and a monitor compares it at that point. The flag checks read the status only between slots.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic urun;
    logic empty;
  } sertx_stat_t;
endpackage

// File: rtl/sertx_slotdet.sv
module sertx_slotdet (
  input  logic bclk_en,
  input  logic fsync,
  input  logic net_mode,
  input  logic slot_en,
  output logic slot_go,
  output logic slot_off
);
  logic frame_edge;

  always_comb begin
    frame_edge = bclk_en && fsync;
    slot_go    = frame_edge && (!net_mode || slot_en);
    slot_off   = frame_edge && net_mode && !slot_en;
  end
endmodule

// File: rtl/sertx_hostif.sv
module sertx_hostif
  import sertx_pkg::*;
#(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_OK  = 8'h10,
  parameter logic [VEC_W-1:0] VEC_EXC = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_data,
  input  logic [WORD_W-1:0] wdata,
  input  logic              wr_slot,
  input  logic              rd_stat,
  input  logic              tx_ie,
  input  logic              slot_go,
  output logic [WORD_W-1:0] hold_word,
  output logic              hold_full,
  output logic [1:0]        stat_rdata,
  output logic              tx_irq,
  output logic [VEC_W-1:0]  tx_vec
);
  logic        empty_q;
  logic        urun_q;
  logic        armed_q;
  logic        slot_ok_q;
  logic        any_wr;
  sertx_stat_t stat_now;

  always_comb begin
    any_wr         = wr_data || wr_slot;
    stat_now.urun  = urun_q;
    stat_now.empty = empty_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_word  <= '0;
      hold_full  <= 1'b0;
      empty_q    <= 1'b1;
      urun_q     <= 1'b0;
      armed_q    <= 1'b0;
      slot_ok_q  <= 1'b0;
      stat_rdata <= '0;
      tx_irq     <= 1'b0;
      tx_vec     <= VEC_OK;
    end else begin
      // clear sequence: armed read, then a write
      if (any_wr && armed_q) begin
        urun_q  <= 1'b0;
        armed_q <= 1'b0;
      end else if (rd_stat && urun_q) begin
        armed_q <= 1'b1;
      end
      // slot start consumes the held word or the slot permission
      if (slot_go) begin
        hold_full <= 1'b0;
        empty_q   <= 1'b1;
        slot_ok_q <= 1'b0;
        if (!hold_full && !slot_ok_q) urun_q <= 1'b1;
      end
      if (wr_data) begin
        hold_word <= wdata;
        hold_full <= 1'b1;
        empty_q   <= 1'b0;
      end
      if (wr_slot) begin
        slot_ok_q <= 1'b1;
        empty_q   <= 1'b0;
      end
      if (rd_stat) stat_rdata <= stat_now;
      tx_irq <= empty_q && tx_ie;
      tx_vec <= urun_q ? VEC_EXC : VEC_OK;
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_en,
  input  logic              slot_go,
  input  logic              slot_off,
  input  logic              ld_new,
  input  logic [WORD_W-1:0] new_word,
  output logic              txd
);
  localparam int unsigned CNT_W = $clog2(WORD_W + 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] last_word;
  logic [WORD_W-1:0] nxt_word;
  logic [CNT_W-1:0]  bits_left;

  always_comb nxt_word = ld_new ? new_word : last_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      last_word <= '0;
      bits_left <= '0;
      txd       <= 1'b0;
    end else if (slot_go) begin
      last_word <= nxt_word;
      txd       <= nxt_word[WORD_W-1];
      shreg     <= nxt_word << 1;
      bits_left <= CNT_W'(WORD_W - 1);
    end else if (slot_off) begin
      bits_left <= '0;
      txd       <= 1'b0;
    end else if (bclk_en) begin
      if (bits_left != '0) begin
        txd       <= shreg[WORD_W-1];
        shreg     <= shreg << 1;
        bits_left <= bits_left - 1'b1;
      end else begin
        txd <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_OK  = 8'h10,
  parameter logic [VEC_W-1:0] VEC_EXC = 8'h12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk_en,
  input  logic              fsync,
  input  logic              net_mode,
  input  logic              slot_en,
  input  logic              host_wr_data,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              host_wr_slot,
  input  logic              host_rd_stat,
  input  logic              tx_ie,
  output logic [1:0]        stat_rdata,
  output logic              txd,
  output logic              tx_irq,
  output logic [VEC_W-1:0]  tx_vec
);
  logic              slot_go;
  logic              slot_off;
  logic              hold_full;
  logic [WORD_W-1:0] hold_word;

  sertx_slotdet u_slotdet (
    .bclk_en (bclk_en),
    .fsync   (fsync),
    .net_mode(net_mode),
    .slot_en (slot_en),
    .slot_go (slot_go),
    .slot_off(slot_off)
  );

  sertx_hostif #(
    .WORD_W (WORD_W),
    .VEC_W  (VEC_W),
    .VEC_OK (VEC_OK),
    .VEC_EXC(VEC_EXC)
  ) u_hostif (
    .clk       (clk),
    .rst       (rst),
    .wr_data   (host_wr_data),
    .wdata     (host_wdata),
    .wr_slot   (host_wr_slot),
    .rd_stat   (host_rd_stat),
    .tx_ie     (tx_ie),
    .slot_go   (slot_go),
    .hold_word (hold_word),
    .hold_full (hold_full),
    .stat_rdata(stat_rdata),
    .tx_irq    (tx_irq),
    .tx_vec    (tx_vec)
  );

  sertx_shifter #(
    .WORD_W(WORD_W)
  ) u_shifter (
    .clk     (clk),
    .rst     (rst),
    .bclk_en (bclk_en),
    .slot_go (slot_go),
    .slot_off(slot_off),
    .ld_new  (hold_full),
    .new_word(hold_word),
    .txd     (txd)
  );
endmodule

// File: rtl/sertx_core_chk.sv
module sertx_core_chk #(
  parameter int unsigned VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_EXC = 8'h12
) (
  input logic             clk,
  input logic             rst,
  input logic             slot_go,
  input logic             slot_off,
  input logic             host_wr_data,
  input logic             host_wr_slot,
  input logic             host_rd_stat,
  input logic             tx_ie,
  input logic [1:0]       stat_rdata,
  input logic             txd,
  input logic             tx_irq,
  input logic [VEC_W-1:0] tx_vec
);
  logic vec_exc;
  always_comb vec_exc = (tx_vec == VEC_EXC);

  // R6
  urun_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(vec_exc) |-> $past(slot_go, 2));

  // R9
  urun_clr_src_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(vec_exc) |-> $past(host_wr_data || host_wr_slot, 2));

  // R2
  wr_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(host_wr_data || host_wr_slot, 2) |-> !tx_irq);

  // R8
  irq_needs_ie_chk: assert property (@(posedge clk) disable iff (rst)
    !tx_ie |=> !tx_irq);

  // R5
  off_slot_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    slot_off |=> !txd);

  // R10
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !host_rd_stat |=> $stable(stat_rdata));
endmodule

bind sertx_core sertx_core_chk #(
  .VEC_W  (VEC_W),
  .VEC_EXC(VEC_EXC)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .slot_go     (slot_go),
  .slot_off    (slot_off),
  .host_wr_data(host_wr_data),
  .host_wr_slot(host_wr_slot),
  .host_rd_stat(host_rd_stat),
  .tx_ie       (tx_ie),
  .stat_rdata  (stat_rdata),
  .txd         (txd),
  .tx_irq      (tx_irq),
  .tx_vec      (tx_vec)
);

// File: tb/test_sertx_core.sv
module test_sertx_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [7:0] V_OK  = 8'h10;
  localparam logic [7:0] V_EXC = 8'h12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bclk_en = 0, fsync = 0, net_mode = 0, slot_en = 0;
  logic         host_wr_data = 0, host_wr_slot = 0, host_rd_stat = 0, tx_ie = 0;
  logic [W-1:0] host_wdata = '0;
  logic [1:0]   stat_rdata;
  logic         txd, tx_irq;
  logic [7:0]   tx_vec;

  int n_run = 0;
  int n_fail = 0;
  logic  exp_q[$];
  string tag_q[$];
  event  mon_ev;

  sertx_core i_sertx_core (
    .clk(clk), .rst(rst), .bclk_en(bclk_en), .fsync(fsync),
    .net_mode(net_mode), .slot_en(slot_en),
    .host_wr_data(host_wr_data), .host_wdata(host_wdata),
    .host_wr_slot(host_wr_slot), .host_rd_stat(host_rd_stat),
    .tx_ie(tx_ie), .stat_rdata(stat_rdata), .txd(txd),
    .tx_irq(tx_irq), .tx_vec(tx_vec)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor: one expected bit per bit enable
  always @(mon_ev) begin
    logic  e;
    string t;
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    check(t, {31'd0, txd}, {31'd0, e});
  end

  task automatic tick(input logic first, input logic en);
    @(negedge clk);
    bclk_en = 1'b1; fsync = first; slot_en = en;
    @(negedge clk);
    bclk_en = 1'b0; fsync = 1'b0;
    ->mon_ev;
  endtask

  // driver: pushes the expected bits of one slot, then clocks it
  task automatic run_slot(input logic en, input logic [W-1:0] word,
                          input logic active, input string tag);
    for (int i = 0; i <= W; i++) begin
      exp_q.push_back((active && i < W) ? word[W-1-i] : 1'b0);
      tag_q.push_back(tag);
    end
    for (int i = 0; i <= W; i++) tick(i == 0, en);
  endtask

  task automatic write_data(input logic [W-1:0] d);
    @(negedge clk); host_wr_data = 1'b1; host_wdata = d;
    @(negedge clk); host_wr_data = 1'b0;
  endtask

  task automatic write_slot();
    @(negedge clk); host_wr_slot = 1'b1;
    @(negedge clk); host_wr_slot = 1'b0;
  endtask

  task automatic read_stat(input string tag, input logic [1:0] exp);
    @(negedge clk); host_rd_stat = 1'b1;
    @(negedge clk); host_rd_stat = 1'b0;
    check(tag, {30'd0, stat_rdata}, {30'd0, exp});
  endtask

  task automatic check_irq(input string tag, input logic irq, input logic [7:0] vec);
    repeat (2) @(negedge clk);
    check(tag, {31'd0, tx_irq}, {31'd0, irq});
    check(tag, {24'd0, tx_vec}, {24'd0, vec});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 txd", {31'd0, txd}, 32'd0);
    check_irq("R1 irq", 1'b0, V_OK);
    read_stat("R1 status", 2'b01);

    tx_ie = 1'b1;
    check_irq("R8 irq on empty", 1'b1, V_OK);

    write_data(16'h1111);
    write_data(16'hA5C3);
    read_stat("R2 empty cleared", 2'b00);
    check_irq("R2 irq dropped", 1'b0, V_OK);

    // normal mode, slot_en low has no effect
    run_slot(1'b0, 16'hA5C3, 1'b1, "R3/R4 normal slot");
    read_stat("R11 empty set", 2'b01);

    run_slot(1'b0, 16'hA5C3, 1'b1, "R6 resend");
    check_irq("R8 exception vector", 1'b1, V_EXC);

    write_data(16'h1234);
    read_stat("R9 write without read keeps flag", 2'b10);
    write_data(16'h5678);
    read_stat("R9 read then write clears", 2'b00);
    check_irq("R8 ok vector", 1'b0, V_OK);

    run_slot(1'b1, 16'h5678, 1'b1, "R2 overwrite");
    read_stat("R11 empty after slot", 2'b01);

    write_slot();
    read_stat("R7 slot write clears empty", 2'b00);
    run_slot(1'b1, 16'h5678, 1'b1, "R7 slot repeat");
    read_stat("R7 no underrun", 2'b01);

    net_mode = 1'b1;
    write_data(16'h9ABC);
    run_slot(1'b0, 16'h0000, 1'b0, "R5 disabled slot");
    read_stat("R5 flags kept", 2'b00);
    run_slot(1'b1, 16'h9ABC, 1'b1, "R5 enabled slot");
    read_stat("R11 net empty", 2'b01);
    run_slot(1'b1, 16'h9ABC, 1'b1, "R6 net underrun");
    read_stat("R6 net flag", 2'b11);
    write_slot();
    read_stat("R9 slot write clears", 2'b00);
    read_stat("R10 stat reread", 2'b00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule